// File: doc/BRIEF.md
# Raster Split, Scroll and Line Interrupt Unit

This unit sits beside a CRT address generator and modifies its output on the way to video memory. It offers three functions. The first is a horizontal split screen: below a chosen scan line, the picture is fetched from a second start address. The second is a scan-line interrupt, which can replace the legacy periodic raster interrupt. The third is a pixel-level soft scroll. The soft scroll shifts the image right by up to fifteen high-resolution pixels and shifts it up by up to seven scan lines. It can also widen the left border over the first character cell of every line to hide the shifted-in garbage.

The CPU programs five byte-wide registers through a simple write strobe. The base timing logic supplies the following each cycle:

- the character-cell memory address and the scan line within the row,
- the display enable,
- a pulse at the end of every scan line,
- a pulse at the start of every frame,
- the legacy periodic interrupt pulse.

The unit returns the adjusted memory address, the adjusted scan-line bits, the horizontal delay for the pixel shifter, a border mask and a sticky interrupt request. Scan lines are numbered from 1, counting the line-end pulses seen since the last frame-start pulse.

Top module: `rastfx_unit`

## Requirements
- R1: Until registers are written after reset, all three functions are inactive. `vma` equals `ma_in`, `vra` equals `ra_in`, `pix_delay` is 0, and `border_mask` and `irq` are 0.
- R2: While the split line register (select 1) holds 0 and no split has started in the frame, `vma` equals `ma_in`.
- R3: A split starts when line N ends and the split line register holds a non-zero value N. From then on, `vma` equals `ma_in` plus the offset captured on the first displayed cycle after that line end, modulo 2^MA_W. This lasts until the next frame-start pulse, which restores `vma` equal to `ma_in` from the following cycle.
- R4: On the first display-enabled cycle after the split line ends, `vma` equals the lower start address. That address takes bits 13..8 from data bits 5..0 written at select 2, and bits 7..0 from the byte written at select 3.
- R5: While the interrupt line register (select 0) holds a non-zero value N, `irq` rises in the cycle after line N ends, and legacy interrupt pulses have no effect.
- R6: While the interrupt line register holds 0, each legacy interrupt pulse sets `irq` from the next cycle.
- R7: `irq` stays high until `irq_ack` is sampled high. An acknowledge clears it unless a new interrupt event occurs in the same cycle, in which case it stays set.
- R8: Rewriting the interrupt line register during a frame gives a further interrupt at the new line in the same frame.
- R9: `pix_delay` equals bits 3..0 of the scroll register (select 4) from the cycle after the write.
- R10: `vra` equals `ra_in` plus scroll bits 6..4, modulo 8. The vertical shift does not change `vma`.
- R11: `border_mask` is high exactly when scroll bit 7 is set and the cycle is the first display-enabled cycle of a line, meaning `de_in` is high and was low in the previous cycle.
- R12: The scroll shift and delay apply the same way on lines below the split.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 interrupt line, 1 split line, 2 lower start high, 3 lower start low, 4 scroll |
| reg_wdata | input | 8 | Register write data |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| line_end | input | 1 | One-cycle pulse at the end of each scan line |
| legacy_irq | input | 1 | Legacy periodic raster interrupt pulse |
| irq_ack | input | 1 | Interrupt acknowledge |
| de_in | input | 1 | Display enable |
| ma_in | input | MA_W | Memory address from the address generator |
| ra_in | input | 3 | Scan line within the character row |
| vma | output | MA_W | Adjusted video memory address |
| vra | output | 3 | Adjusted scan-line bits |
| pix_delay | output | 4 | Horizontal pixel delay for the shifter |
| border_mask | output | 1 | Border extension over the first character cell |
| irq | output | 1 | Interrupt request |

## Verification
The bench places the split line, and separately the interrupt line, on a line just before the end of a character row, on the last line of the frame, and beyond the frame. A design that captured the lower start address one cycle late would show the upper screen for one character. A design that failed to clear the split at frame start would carry the lower screen into the next frame. Acknowledges are made to coincide with interrupt events, and the interrupt line register is rewritten mid-frame; a clear-wins priority or a latched compare value would lose the second interrupt. Vertical scroll values near 7 paired with high scan lines expose a sum that carries into the address instead of wrapping. The border mask is checked on every cycle, so a mask that lasts longer than one character would be caught.

// File: rtl/rastfx_pkg.sv
package rastfx_pkg;

  localparam int unsigned REG_W = 8;
  localparam int unsigned RA_W  = 3;
  localparam int unsigned HD_W  = 4;

  typedef enum logic [2:0] {
    SEL_IRQ_LINE   = 3'd0,
    SEL_SPLIT_LINE = 3'd1,
    SEL_START_HI   = 3'd2,
    SEL_START_LO   = 3'd3,
    SEL_SCROLL     = 3'd4
  } rsel_e;

  typedef struct packed {
    logic            border_ext;
    logic [RA_W-1:0] vshift;
    logic [HD_W-1:0] hdelay;
  } scroll_t;

endpackage

// File: rtl/rastfx_regs.sv
module rastfx_regs
  import rastfx_pkg::*;
#(
  parameter int unsigned MA_W   = 14,
  parameter int unsigned LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  output logic [LINE_W-1:0] irq_line,
  output logic [LINE_W-1:0] split_line,
  output logic [MA_W-1:0]   lower_start,
  output scroll_t           scroll
);

  localparam int unsigned HI_W = MA_W - REG_W;

  logic [LINE_W-1:0] irq_line_d, split_line_d;
  logic [MA_W-1:0]   lower_start_d;
  scroll_t           scroll_d;

  always_comb begin
    irq_line_d    = irq_line;
    split_line_d  = split_line;
    lower_start_d = lower_start;
    scroll_d      = scroll;
    if (wr_en) begin
      case (rsel_e'(wr_sel))
        SEL_IRQ_LINE:   irq_line_d   = wr_data[LINE_W-1:0];
        SEL_SPLIT_LINE: split_line_d = wr_data[LINE_W-1:0];
        SEL_START_HI:   lower_start_d[MA_W-1:REG_W] = wr_data[HI_W-1:0];
        SEL_START_LO:   lower_start_d[REG_W-1:0]    = wr_data;
        SEL_SCROLL:     scroll_d     = scroll_t'(wr_data);
        default:        ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_line    <= '0;
      split_line  <= '0;
      lower_start <= '0;
      scroll      <= '0;
    end else begin
      irq_line    <= irq_line_d;
      split_line  <= split_line_d;
      lower_start <= lower_start_d;
      scroll      <= scroll_d;
    end
  end

endmodule

// File: rtl/rastfx_split.sv
module rastfx_split #(
  parameter int unsigned MA_W   = 14,
  parameter int unsigned LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_end,
  input  logic              de_in,
  input  logic [MA_W-1:0]   ma_in,
  input  logic [LINE_W-1:0] split_line,
  input  logic [MA_W-1:0]   lower_start,
  output logic [LINE_W-1:0] ending_line,
  output logic              de_first,
  output logic [MA_W-1:0]   vma
);

  logic [LINE_W-1:0] line_cnt, line_cnt_d;
  logic              pend_q, pend_d;
  logic              act_q, act_d;
  logic [MA_W-1:0]   off_q, off_d;
  logic              de_q;
  logic              capture;
  logic              split_hit;

  assign ending_line = line_cnt + LINE_W'(1);
  assign de_first    = de_in & ~de_q;
  assign capture     = pend_q & de_first;
  assign split_hit   = line_end & (split_line != '0) & (ending_line == split_line);

  always_comb begin
    line_cnt_d = line_cnt;
    pend_d     = pend_q;
    act_d      = act_q;
    off_d      = off_q;
    if (frame_start) begin
      line_cnt_d = '0;
      pend_d     = 1'b0;
      act_d      = 1'b0;
    end else begin
      if (line_end) line_cnt_d = ending_line;
      if (split_hit) pend_d = 1'b1;
      else if (capture) pend_d = 1'b0;
      if (capture) begin
        act_d = 1'b1;
        off_d = lower_start - ma_in;
      end
    end
  end

  always_comb begin
    if (capture)    vma = lower_start;
    else if (act_q) vma = ma_in + off_q;
    else            vma = ma_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt <= '0;
      pend_q   <= 1'b0;
      act_q    <= 1'b0;
      off_q    <= '0;
      de_q     <= 1'b0;
    end else begin
      line_cnt <= line_cnt_d;
      pend_q   <= pend_d;
      act_q    <= act_d;
      off_q    <= off_d;
      de_q     <= de_in;
    end
  end

endmodule

// File: rtl/rastfx_irq.sv
module rastfx_irq #(
  parameter int unsigned LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_end,
  input  logic              legacy_irq,
  input  logic              irq_ack,
  input  logic [LINE_W-1:0] ending_line,
  input  logic [LINE_W-1:0] irq_line,
  output logic              irq
);

  logic prog_mode;
  logic set_evt;
  logic irq_d;

  assign prog_mode = (irq_line != '0);

  always_comb begin
    if (prog_mode) set_evt = line_end & (ending_line == irq_line);
    else           set_evt = legacy_irq;
    irq_d = set_evt | (irq & ~irq_ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

endmodule

// File: rtl/rastfx_scroll.sv
module rastfx_scroll
  import rastfx_pkg::*;
(
  input  scroll_t         scroll,
  input  logic [RA_W-1:0] ra_in,
  input  logic            de_first,
  output logic [RA_W-1:0] vra,
  output logic [HD_W-1:0] pix_delay,
  output logic            border_mask
);

  always_comb begin
    vra         = ra_in + scroll.vshift;
    pix_delay   = scroll.hdelay;
    border_mask = scroll.border_ext & de_first;
  end

endmodule

// File: rtl/rastfx_unit.sv
module rastfx_unit
  import rastfx_pkg::*;
#(
  parameter int unsigned MA_W   = 14,
  parameter int unsigned LINE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             frame_start,
  input  logic             line_end,
  input  logic             legacy_irq,
  input  logic             irq_ack,
  input  logic             de_in,
  input  logic [MA_W-1:0]  ma_in,
  input  logic [RA_W-1:0]  ra_in,
  output logic [MA_W-1:0]  vma,
  output logic [RA_W-1:0]  vra,
  output logic [HD_W-1:0]  pix_delay,
  output logic             border_mask,
  output logic             irq
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [LINE_W-1:0] irq_line_w;
  logic [LINE_W-1:0] split_line_w;
  logic [MA_W-1:0]   lower_start_w;
  scroll_t           scroll_w;
  logic [LINE_W-1:0] ending_line_w;
  logic              de_first_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  rastfx_regs #(.MA_W(MA_W), .LINE_W(LINE_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (reg_wr),
    .wr_sel      (reg_sel),
    .wr_data     (reg_wdata),
    .irq_line    (irq_line_w),
    .split_line  (split_line_w),
    .lower_start (lower_start_w),
    .scroll      (scroll_w)
  );

  rastfx_split #(.MA_W(MA_W), .LINE_W(LINE_W)) u_split (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .frame_start (frame_start),
    .line_end    (line_end),
    .de_in       (de_in),
    .ma_in       (ma_in),
    .split_line  (split_line_w),
    .lower_start (lower_start_w),
    .ending_line (ending_line_w),
    .de_first    (de_first_w),
    .vma         (vma)
  );

  rastfx_irq #(.LINE_W(LINE_W)) u_irq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .line_end    (line_end),
    .legacy_irq  (legacy_irq),
    .irq_ack     (irq_ack),
    .ending_line (ending_line_w),
    .irq_line    (irq_line_w),
    .irq         (irq)
  );

  rastfx_scroll u_scroll (
    .scroll      (scroll_w),
    .ra_in       (ra_in),
    .de_first    (de_first_w),
    .vra         (vra),
    .pix_delay   (pix_delay),
    .border_mask (border_mask)
  );

endmodule

// File: rtl/rastfx_unit_chk.sv
module rastfx_unit_chk #(
  parameter int unsigned MA_W   = 14,
  parameter int unsigned LINE_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              reg_wr,
  input logic [2:0]        reg_sel,
  input logic [7:0]        reg_wdata,
  input logic              frame_start,
  input logic              line_end,
  input logic              legacy_irq,
  input logic              irq_ack,
  input logic              de_in,
  input logic [MA_W-1:0]   ma_in,
  input logic [MA_W-1:0]   vma,
  input logic [3:0]        pix_delay,
  input logic              border_mask,
  input logic              irq,
  input logic [LINE_W-1:0] irq_line_w
);

  p_hdelay_load_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && reg_sel == 3'd4) |=> (pix_delay == $past(reg_wdata[3:0])));

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq && !irq_ack) |=> irq);

  p_irq_source_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq) |-> $past(line_end || legacy_irq));

  p_legacy_masked_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_line_w != '0 && legacy_irq && !line_end && !irq && !reg_wr) |=> !irq);

  p_mask_in_display_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    border_mask |-> de_in);

  p_split_cleared_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_start |=> (vma == ma_in));

endmodule

bind rastfx_unit rastfx_unit_chk #(.MA_W(MA_W), .LINE_W(LINE_W)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .reg_wr      (reg_wr),
  .reg_sel     (reg_sel),
  .reg_wdata   (reg_wdata),
  .frame_start (frame_start),
  .line_end    (line_end),
  .legacy_irq  (legacy_irq),
  .irq_ack     (irq_ack),
  .de_in       (de_in),
  .ma_in       (ma_in),
  .vma         (vma),
  .pix_delay   (pix_delay),
  .border_mask (border_mask),
  .irq         (irq),
  .irq_line_w  (irq_line_w)
);

// File: tb/rastfx_unit_test.sv
module rastfx_unit_test;

  localparam int W    = 4;
  localparam int ROWS = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic        frame_start = 1'b0, line_end = 1'b0, legacy_irq = 1'b0, irq_ack = 1'b0;
  logic        de_in = 1'b0;
  logic [13:0] ma_in = '0;
  logic [2:0]  ra_in = '0;
  logic [13:0] vma;
  logic [2:0]  vra;
  logic [3:0]  pix_delay;
  logic        border_mask, irq;

  always #2 clk = ~clk;

  rastfx_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .frame_start(frame_start), .line_end(line_end), .legacy_irq(legacy_irq), .irq_ack(irq_ack),
    .de_in(de_in), .ma_in(ma_in), .ra_in(ra_in), .vma(vma), .vra(vra),
    .pix_delay(pix_delay), .border_mask(border_mask), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;

  // expected-state model
  logic [7:0]  m_il = 0, m_split = 0, m_scr = 0, m_lc = 0;
  logic [13:0] m_lower = 0, m_off = 0;
  logic        m_pend = 0, m_act = 0, m_deq = 0, m_irq = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic        cap, set, xm;
    logic [13:0] ev;
    logic [2:0]  er;
    logic [7:0]  nlc;
    logic        npend, nact, nirq;
    logic [13:0] noff;
    #1;
    cap = m_pend && de_in && !m_deq;
    ev  = cap ? m_lower : (m_act ? ma_in + m_off : ma_in);
    chk(cap ? "R4" : ((m_split == 0 && !m_act) ? "R2" : "R3"), int'(vma), int'(ev));
    er = ra_in + m_scr[6:4];
    chk(m_act ? "R12" : "R10", int'(vra), int'(er));
    chk(m_act ? "R12" : "R9", int'(pix_delay), int'(m_scr[3:0]));
    xm = m_scr[7] && de_in && !m_deq;
    chk("R11", int'(border_mask), int'(xm));
    chk(irq_ack ? "R7" : (m_il != 0 ? "R5" : "R6"), int'(irq), int'(m_irq));
    // next state from requirements
    nlc = frame_start ? 8'd0 : (line_end ? m_lc + 8'd1 : m_lc);
    npend = m_pend; nact = m_act; noff = m_off;
    if (frame_start) begin npend = 0; nact = 0; end
    else begin
      if (line_end && m_split != 0 && (m_lc + 8'd1) == m_split) npend = 1;
      else if (cap) npend = 0;
      if (cap) begin nact = 1; noff = m_lower - ma_in; end
    end
    set  = (m_il != 0) ? (line_end && (m_lc + 8'd1) == m_il) : legacy_irq;
    nirq = set || (m_irq && !irq_ack);
    m_lc = nlc; m_pend = npend; m_act = nact; m_off = noff; m_irq = nirq; m_deq = de_in;
    if (reg_wr) begin
      case (reg_sel)
        3'd0: m_il = reg_wdata;
        3'd1: m_split = reg_wdata;
        3'd2: m_lower[13:8] = reg_wdata[5:0];
        3'd3: m_lower[7:0] = reg_wdata;
        3'd4: m_scr = reg_wdata;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    reg_wr = 0; frame_start = 0; line_end = 0; legacy_irq = 0; irq_ack = 0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    reg_wr = 1; reg_sel = s; reg_wdata = d; de_in = 0;
    tick();
  endtask

  task automatic do_line(input logic [13:0] base, input logic [2:0] r,
                         input logic leg, input logic ack);
    for (int c = 0; c < W; c++) begin
      de_in = 1; ma_in = base + 14'(c); ra_in = r;
      tick();
    end
    de_in = 0; irq_ack = ack;
    tick();
    line_end = 1; legacy_irq = leg;
    tick();
  endtask

  task automatic new_frame();
    de_in = 0; frame_start = 1;
    tick();
  endtask

  task automatic run_frame(input logic [13:0] start, input bit rnd);
    new_frame();
    for (int row = 0; row < ROWS; row++)
      for (int s = 0; s < 8; s++) begin
        if (rnd && ($urandom % 8) == 0) begin
          if ($urandom % 2) wr(3'd0, 8'($urandom_range(0, 26)));
          else              wr(3'd4, 8'($urandom));
        end
        do_line(start + 14'(row * W), 3'(s),
                rnd ? (($urandom % 6) == 0) : (s == 3),
                rnd ? (($urandom % 3) == 0) : (s == 5));
      end
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    ma_in = 14'h155; ra_in = 3'd5;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1", int'(vma), 14'h155);
    chk("R1", int'(vra), 5);
    chk("R1", int'(pix_delay), 0);
    chk("R1", int'(border_mask), 0);
    chk("R1", int'(irq), 0);
    @(negedge clk);

    // R2/R6/R7: split off, legacy interrupt path
    run_frame(14'h0100, 0);

    // R3/R4/R10/R11/R12: split at line 5 into 0x2A34, full scroll
    wr(3'd2, 8'hEA);   // upper bits beyond 13..8 ignored
    wr(3'd3, 8'h34);
    wr(3'd1, 8'd5);
    wr(3'd4, 8'hF7);
    run_frame(14'h0200, 0);
    // R3: split cleared by frame start, R2 with split at last line (24)
    wr(3'd1, 8'd24);
    run_frame(14'h0300, 0);
    new_frame();
    chk("R3", int'(m_act), 0);

    // R8: interrupt at line 3, rewritten to 6 in the same frame
    wr(3'd1, 8'd0);
    wr(3'd0, 8'd3);
    for (int l = 1; l <= 10; l++) begin
      do_line(14'h0040, 3'((l - 1) % 8), 1'b1, 1'b0);
      if (l == 3) begin
        chk("R8", int'(irq), 1);
        irq_ack = 1; tick();
        wr(3'd0, 8'd6);
      end
      if (l == 6) begin
        chk("R8", int'(irq), 1);
        irq_ack = 1; tick();
      end
    end
    chk("R8", int'(irq), 0);

    // R7: acknowledge in the same cycle as a new event keeps irq set
    wr(3'd0, 8'd0);
    legacy_irq = 1; tick();
    legacy_irq = 1; irq_ack = 1; tick();
    chk("R7", int'(irq), 1);
    irq_ack = 1; tick();
    chk("R7", int'(irq), 0);

    // random frames
    for (int f = 0; f < 30; f++) begin
      wr(3'd1, 8'($urandom_range(0, 26)));
      wr(3'd2, 8'($urandom));
      wr(3'd3, 8'($urandom));
      wr(3'd0, 8'($urandom_range(0, 26)));
      wr(3'd4, 8'($urandom));
      run_frame(14'($urandom), 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule